// File: doc/BRIEF.md
# Program Memory Security Gate

This block sits between an on-chip program memory and the two agents that can read it. One agent is the code-read path. It carries instruction fetches and table reads, and each request is tagged with whether the instruction that issued it was itself fetched from external program memory. The other agent is a parallel verify port, which reads memory contents out of the device. Two lock bits and a 64-byte key array decide, for each request, whether the memory byte is returned as is, returned scrambled, or withheld.

The lock bits form a protection level. With no bit set, everything is open. With the first bit set alone, code reads issued from external program memory are refused. With the second bit set, verify reads are refused as well. The combination where the second bit is set without the first has no defined meaning, and the block treats it as the strictest level. A verify byte that is allowed out is XNOR-combined with the key byte picked by the low six address bits. An unprogrammed key byte is all ones, so it leaves the data unchanged.

Requests, the access decision and the returned byte are all registered. Each result appears one clock after its request strobe.

Top module: `prog_mem_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rsp_valid` and `rsp_blocked` are 0 and `rsp_data` is 0xFF.
- R2: `rsp_valid` is 1 in exactly the cycle after each cycle with `req_valid` = 1, and 0 otherwise.
- R3: With `lock_a` = 0 and `lock_b` = 0, a code read (`req_verify` = 0) returns the memory byte unchanged and unblocked, for either value of `req_ext`.
- R4: An allowed verify read (`req_verify` = 1, `lock_b` = 0) returns `~(mem_data ^ K)`, where K is `key_flat[8*i +: 8]` and i = `addr[5:0]`. With K = 0xFF the plain byte comes back.
- R5: With `lock_a` = 1 and `lock_b` = 0, a code read with `req_ext` = 1 is blocked. A verify read is still allowed, as in R4.
- R6: A code read with `req_ext` = 0 is never blocked and returns the memory byte unchanged, at every lock setting.
- R7: With `lock_a` = 1 and `lock_b` = 1, verify reads are blocked and code reads with `req_ext` = 1 are blocked.
- R8: With `lock_a` = 0 and `lock_b` = 1, the behaviour is the same as in R7.
- R9: A blocked request returns 0xFF on `rsp_data` with `rsp_blocked` = 1 for that single response cycle. `rsp_blocked` is never 1 without `rsp_valid`.
- R10: Address bits above bit 5 do not affect which key byte is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_a | input | 1 | First lock bit, 1 = programmed |
| lock_b | input | 1 | Second lock bit, 1 = programmed |
| key_flat | input | 512 | Key array; byte i at bits [8*i+7:8*i] |
| req_valid | input | 1 | Request strobe |
| req_verify | input | 1 | 1 = verify read, 0 = code read |
| req_ext | input | 1 | Code read issued by an instruction from external memory |
| addr | input | 14 | Program memory address |
| mem_data | input | 8 | Raw memory byte for `addr`, valid with the strobe |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_data | output | 8 | Returned byte (0xFF when blocked) |
| rsp_blocked | output | 1 | Request was refused |

## Verification
The only internal state in this block is the response register. A wrong decoded lock level or a wrong key index therefore shows up on the very next response: the wrong blocked flag, a 0xFF where a byte was due, or a byte scrambled with the wrong key. A lost or extra strobe shows as `rsp_valid` out of step with the requests within one cycle. Key indexing is exercised with distinct key bytes and addresses that differ only above bit 5, so that a mis-sliced index changes the data.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN   = 2'd0,
        LVL_NOEXT  = 2'd1,
        LVL_SEALED = 2'd2
    } lock_lvl_e;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'd0,
        ACT_SCRAM = 2'd1,
        ACT_DENY  = 2'd2
    } action_e;

    // undefined combination (second bit alone) maps to the strictest level
    function automatic lock_lvl_e decode_lock(input logic bit_a, input logic bit_b);
        if (bit_b)
            return LVL_SEALED;
        else if (bit_a)
            return LVL_NOEXT;
        else
            return LVL_OPEN;
    endfunction

    function automatic action_e choose_action(input lock_lvl_e lvl,
                                              input logic is_verify,
                                              input logic from_ext);
        if (is_verify)
            return (lvl == LVL_SEALED) ? ACT_DENY : ACT_SCRAM;
        else if (from_ext && (lvl != LVL_OPEN))
            return ACT_DENY;
        else
            return ACT_PASS;
    endfunction

endpackage

// File: rtl/pmg_lock_decode.sv
module pmg_lock_decode
    import pmg_pkg::*;
(
    input  logic      lock_a,
    input  logic      lock_b,
    output lock_lvl_e level
);
    always_comb level = decode_lock(lock_a, lock_b);
endmodule

// File: rtl/pmg_key_select.sv
module pmg_key_select #(
    parameter int DATA_W    = 8,
    parameter int KEY_DEPTH = 64,
    localparam int IDX_W    = $clog2(KEY_DEPTH)
) (
    input  logic [KEY_DEPTH*DATA_W-1:0] key_flat,
    input  logic [IDX_W-1:0]            idx,
    output logic [DATA_W-1:0]           key_byte
);
    logic [DATA_W-1:0] key_arr [KEY_DEPTH];

    for (genvar g = 0; g < KEY_DEPTH; g++) begin : g_unpack
        assign key_arr[g] = key_flat[g*DATA_W +: DATA_W];
    end

    assign key_byte = key_arr[idx];
endmodule

// File: rtl/pmg_policy.sv
module pmg_policy
    import pmg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  lock_lvl_e         level,
    input  logic              is_verify,
    input  logic              from_ext,
    input  logic [DATA_W-1:0] raw,
    input  logic [DATA_W-1:0] key_byte,
    output logic [DATA_W-1:0] out_byte,
    output logic              denied
);
    action_e act;

    always_comb begin
        act      = choose_action(level, is_verify, from_ext);
        denied   = 1'b0;
        out_byte = raw;
        unique case (act)
            ACT_PASS:  out_byte = raw;
            ACT_SCRAM: out_byte = ~(raw ^ key_byte);
            default: begin
                out_byte = '1;
                denied   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/prog_mem_guard.sv
module prog_mem_guard
    import pmg_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 8,
    parameter int KEY_DEPTH = 64,
    localparam int IDX_W    = $clog2(KEY_DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        lock_a,
    input  logic                        lock_b,
    input  logic [KEY_DEPTH*DATA_W-1:0] key_flat,
    input  logic                        req_valid,
    input  logic                        req_verify,
    input  logic                        req_ext,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           mem_data,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        rsp_blocked
);
    lock_lvl_e         level;
    logic [DATA_W-1:0] key_byte;
    logic [DATA_W-1:0] next_byte;
    logic              next_deny;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:IDX_W];

    pmg_lock_decode u_dec (
        .lock_a (lock_a),
        .lock_b (lock_b),
        .level  (level)
    );

    pmg_key_select #(.DATA_W(DATA_W), .KEY_DEPTH(KEY_DEPTH)) u_key (
        .key_flat (key_flat),
        .idx      (addr[IDX_W-1:0]),
        .key_byte (key_byte)
    );

    pmg_policy #(.DATA_W(DATA_W)) u_pol (
        .level     (level),
        .is_verify (req_verify),
        .from_ext  (req_ext),
        .raw       (mem_data),
        .key_byte  (key_byte),
        .out_byte  (next_byte),
        .denied    (next_deny)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_blocked <= 1'b0;
            rsp_data    <= '1;
        end else begin
            rsp_valid   <= req_valid;
            rsp_blocked <= req_valid & next_deny;
            if (req_valid)
                rsp_data <= next_byte;
        end
    end
endmodule

// File: rtl/pmg_guard_chk.sv
module pmg_guard_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              lock_a,
    input logic              lock_b,
    input logic              req_valid,
    input logic              req_verify,
    input logic              req_ext,
    input logic [DATA_W-1:0] mem_data,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_blocked
);
    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R9
    blocked_shape_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_blocked |-> (rsp_valid && rsp_data == '1));
    // R6
    internal_free_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_verify && !req_ext) |=>
            (!rsp_blocked && rsp_data == $past(mem_data)));
    // R3
    open_code_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_verify && !lock_a && !lock_b) |=>
            (!rsp_blocked && rsp_data == $past(mem_data)));
    // R5
    ext_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_verify && req_ext && (lock_a || lock_b)) |=> rsp_blocked);
    // R7 R8
    verify_seal_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_verify && lock_b) |=> rsp_blocked);
    // R4
    verify_open_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_verify && !lock_b) |=> !rsp_blocked);
endmodule

bind prog_mem_guard pmg_guard_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/prog_mem_guard_test.sv
module prog_mem_guard_test;
    localparam int AW = 14;
    localparam int DW = 8;
    localparam int KD = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lock_a = 1'b0, lock_b = 1'b0;
    logic [KD*DW-1:0]  key_flat = '1;
    logic              req_valid = 1'b0, req_verify = 1'b0, req_ext = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [DW-1:0]     mem_data = '0;
    logic              rsp_valid, rsp_blocked;
    logic [DW-1:0]     rsp_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [DW-1:0] q_data[$];
    logic          q_blk[$];
    string         q_tag[$];

    always #5 clk = ~clk;

    prog_mem_guard uut (
        .clk(clk), .rst(rst), .lock_a(lock_a), .lock_b(lock_b),
        .key_flat(key_flat), .req_valid(req_valid), .req_verify(req_verify),
        .req_ext(req_ext), .addr(addr), .mem_data(mem_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_blocked(rsp_blocked)
    );

    function automatic logic [DW-1:0] mem_of(logic [AW-1:0] a);
        return a[7:0] ^ {a[13:8], 2'b01} ^ 8'h5A;
    endfunction

    task automatic fill_key(bit all_ones);
        for (int i = 0; i < KD; i++)
            key_flat[i*DW +: DW] = all_ones ? 8'hFF : 8'(i * 37 + 11);
    endtask

    task automatic issue(logic v, logic e, logic [AW-1:0] a, string tag);
        logic [DW-1:0] m, k, exp_d;
        logic exp_b;
        m = mem_of(a);
        k = key_flat[a[5:0]*DW +: DW];
        exp_b = v ? lock_b : (e && (lock_a || lock_b));
        exp_d = exp_b ? 8'hFF : (v ? ~(m ^ k) : m);
        @(negedge clk);
        req_valid = 1'b1; req_verify = v; req_ext = e; addr = a; mem_data = m;
        q_data.push_back(exp_d); q_blk.push_back(exp_b); q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; mem_data = 8'(i * 13); addr = 14'(i * 301);
        end
    endtask

    task automatic check_drained(string tag);
        total++;
        if (q_data.size() != 0) begin
            bad++;
            $display("FAIL %s: pending=%0d expected=0", tag, q_data.size());
            q_data.delete(); q_blk.delete(); q_tag.delete();
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            total++;
            if (q_data.size() == 0) begin
                bad++;
                $display("FAIL R2: rsp_valid=1 with no request, expected 0");
            end else begin
                logic [DW-1:0] ed;
                logic eb;
                string t;
                ed = q_data.pop_front(); eb = q_blk.pop_front(); t = q_tag.pop_front();
                if (rsp_data !== ed || rsp_blocked !== eb) begin
                    bad++;
                    $display("FAIL %s: data=%h blocked=%b expected data=%h blocked=%b",
                             t, rsp_data, rsp_blocked, ed, eb);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        fill_key(1'b0);
        repeat (3) @(negedge clk);
        // R1 during reset
        total++;
        if (rsp_valid !== 1'b0 || rsp_blocked !== 1'b0 || rsp_data !== 8'hFF) begin
            bad++;
            $display("FAIL R1: valid=%b blocked=%b data=%h expected 0 0 ff",
                     rsp_valid, rsp_blocked, rsp_data);
        end
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0 || rsp_blocked !== 1'b0 || rsp_data !== 8'hFF) begin
            bad++;
            $display("FAIL R1: after reset valid=%b blocked=%b data=%h expected 0 0 ff",
                     rsp_valid, rsp_blocked, rsp_data);
        end

        // open level: code reads both origins, verify scrambled
        lock_a = 1'b0; lock_b = 1'b0;
        for (int i = 0; i < 6; i++) issue(1'b0, i[0], 14'(i * 997 + 3), "R3");
        for (int i = 0; i < 6; i++) issue(1'b1, 1'b0, 14'(i * 71 + 5), "R4");
        // R10: same low bits, different high bits
        issue(1'b1, 1'b0, 14'h0025, "R10");
        issue(1'b1, 1'b0, 14'h1FE5, "R10");
        issue(1'b1, 1'b0, 14'h2A65, "R10");
        idle(3);
        check_drained("R2");

        // R4 with unprogrammed key: plain bytes
        fill_key(1'b1);
        for (int i = 0; i < 4; i++) issue(1'b1, 1'b0, 14'(i * 523 + 9), "R4");
        idle(2);
        fill_key(1'b0);

        // first lock bit only
        lock_a = 1'b1; lock_b = 1'b0;
        for (int i = 0; i < 4; i++) issue(1'b0, 1'b1, 14'(i * 131 + 1), "R5");
        for (int i = 0; i < 3; i++) issue(1'b1, 1'b0, 14'(i * 67 + 40), "R5");
        for (int i = 0; i < 3; i++) issue(1'b0, 1'b0, 14'(i * 311 + 2), "R6");
        idle(2);

        // both bits
        lock_a = 1'b1; lock_b = 1'b1;
        for (int i = 0; i < 3; i++) issue(1'b1, 1'b0, 14'(i * 89 + 7), "R7");
        for (int i = 0; i < 3; i++) issue(1'b0, 1'b1, 14'(i * 89 + 8), "R7");
        for (int i = 0; i < 3; i++) issue(1'b0, 1'b0, 14'(i * 401 + 6), "R6");
        idle(2);

        // undefined combination
        lock_a = 1'b0; lock_b = 1'b1;
        for (int i = 0; i < 3; i++) issue(1'b1, 1'b0, 14'(i * 59 + 4), "R8");
        for (int i = 0; i < 3; i++) issue(1'b0, 1'b1, 14'(i * 59 + 12), "R8");
        issue(1'b0, 1'b0, 14'h1234, "R6");
        // R9: blocked then allowed back to back, blocked must drop
        issue(1'b0, 1'b1, 14'h0100, "R9");
        issue(1'b0, 1'b0, 14'h0101, "R9");
        idle(4);
        check_drained("R2");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule